// File: doc/BRIEF.md
# Bitmask Logical Immediate Decoder

This block expands the compact 13-bit immediate carried by bitwise-logic instructions into the full 64-bit operand mask. The packed code holds an element-size flag, a rotation amount and a run-length field. The decoder finds the size of the repeating element, forms a run of ones inside that element and rotates it right. It then copies the element across 64 bits and trims the result to the selected operand width of 32 or 64 bits. An invert control serves the bit-clear form of the instruction, which uses the complement of the mask.

The decoder also judges whether each code is legal. It rejects reserved size codes, a run that would fill a whole element, and a 64-bit element requested for a 32-bit operand. A rejected code gives a zero mask with the legal flag low. The logic is combinational and feeds one output register, so a code presented in one cycle shows its result after the next rising clock edge.

Top module: `bitmask_imm_decoder`

## Requirements
- R1: The code input packs the run-length field in bits 5:0, the rotation field in bits 11:6 and the wide-element flag in bit 12. Example: code 0x1103 on a 64-bit operand decodes to 0xF000_0000_0000_0000.
- R2: With bit 12 set the element is 64 bits. With bit 12 clear the element is 2^p bits, where p is the highest cleared bit of the run-length field. A code whose run-length field has bits 5:1 all set, with bit 12 clear, is illegal (for example 0x003E).
- R3: Inside one element the pattern is (S+1) adjacent ones from bit 0, rotated right by R. S is the run-length field and R is the rotation field, each taken modulo the element size. Code 0x1000 gives 0x1 and code 0x1040 gives 0x8000_0000_0000_0000.
- R4: Rotation bits at or above log2(element size) have no effect. Code 0x0840 (32-bit element, rotation field 0x21) gives 0x8000_0000_8000_0000 on a 64-bit operand.
- R5: A code whose run covers the whole element (S equal to element size minus one) is illegal. Examples are 0x001F and 0x103F.
- R6: The element pattern repeats across all 64 bits. Code 0x003C (2-bit element) gives 0x5555_5555_5555_5555 before width trimming.
- R7: A 64-bit element with the 32-bit operand width selected (wide_i = 0) is illegal.
- R8: With wide_i = 0, bits 63:32 of the mask are always zero.
- R9: With invert_i = 1 and a legal code, the mask is the bitwise complement of the decoded mask within the operand width. Bits above the width stay zero. Code 0x0000 on a 32-bit operand gives 0x0000_0000_FFFF_FFFE.
- R10: For any illegal code, legal_o is 0 and mask_o is zero, whatever the value of invert_i.
- R11: Outputs are registered. A code applied before a rising edge appears on mask_o and legal_o after that edge. A synchronous reset clears both outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_i | input | 13 | Packed immediate: flag, rotation, run length |
| wide_i | input | 1 | 1 selects a 64-bit operand, 0 a 32-bit operand |
| invert_i | input | 1 | 1 complements the mask (bit-clear form) |
| mask_o | output | 64 | Decoded, width-trimmed mask |
| legal_o | output | 1 | 1 when the registered code was legal |

## Verification
The assertions that look back one cycle assume code_i, wide_i and invert_i hold known values during the cycle before each sampling edge, including the cycle in which reset is high. The bench drives every input on the falling edge and keeps it steady across the next rising edge. It holds all inputs at zero while reset is asserted. A behavioural model in the bench predicts the output for every code, for both widths and both invert settings.

// File: rtl/bmi_pkg.sv
package bmi_pkg;
  localparam int DATA_W = 64;
  localparam int LOGW   = $clog2(DATA_W);
  localparam int CODE_W = 2 * LOGW + 1;

  // Field order is fixed by the packed code: flag on top, run length at bottom.
  typedef struct packed {
    logic            wide_elem;
    logic [LOGW-1:0] rot;
    logic [LOGW-1:0] run;
  } bmi_code_t;
endpackage

// File: rtl/bmi_size_detect.sv
module bmi_size_detect #(
  parameter int LOGW = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wide_elem,
  input  logic [LOGW-1:0] run,
  input  logic            wide_op,
  output logic [LOGW:1]   size_sel,
  output logic            legal
);
  logic found;
  logic full_run;
  logic too_wide;

  // One-hot element size: bit p set means element of 2^p bits.
  always_comb begin
    size_sel = '0;
    found    = 1'b0;
    if (wide_elem) begin
      size_sel[LOGW] = 1'b1;
    end else begin
      for (int p = LOGW - 1; p >= 1; p--) begin
        if (!found && !run[p]) begin
          size_sel[p] = 1'b1;
          found       = 1'b1;
        end
      end
    end
  end

  // Run that fills the whole element is reserved.
  always_comb begin
    full_run = 1'b0;
    for (int p = 1; p <= LOGW; p++) begin
      logic [LOGW-1:0] low_mask;
      low_mask = LOGW'((1 << p) - 1);
      if (size_sel[p] && ((run & low_mask) == low_mask))
        full_run = 1'b1;
    end
  end

  assign too_wide = size_sel[LOGW] && !wide_op;
  assign legal    = (|size_sel) && !full_run && !too_wide;

  assert_size_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(size_sel));

  assert_legal_needs_size_R2: assert property (@(posedge clk) disable iff (rst)
    legal |-> ($countones(size_sel) == 1));
endmodule

// File: rtl/bmi_pattern_gen.sv
module bmi_pattern_gen #(
  parameter int LOGE   = 1,
  parameter int DATA_W = 64
) (
  input  logic [LOGE-1:0]   s,
  input  logic [LOGE-1:0]   r,
  output logic [DATA_W-1:0] rep
);
  localparam int E = 1 << LOGE;

  logic [E-1:0] elem;

  // Rotated run: bit i takes source bit (i + r) mod E, which is set when <= s.
  always_comb begin
    for (int i = 0; i < E; i++) begin
      logic [LOGE-1:0] src;
      src     = LOGE'(i) + r;
      elem[i] = (src <= s);
    end
  end

  always_comb begin
    for (int b = 0; b < DATA_W; b++)
      rep[b] = elem[b % E];
  end
endmodule

// File: rtl/bmi_out_stage.sv
module bmi_out_stage #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] pattern,
  input  logic              legal,
  input  logic              wide_op,
  input  logic              invert,
  output logic [DATA_W-1:0] mask_q,
  output logic              legal_q
);
  localparam int HALF = DATA_W / 2;
  localparam logic [DATA_W-1:0] NARROW = {{HALF{1'b0}}, {HALF{1'b1}}};

  logic [DATA_W-1:0] width_mask;
  logic [DATA_W-1:0] shaped;

  assign width_mask = wide_op ? '1 : NARROW;

  always_comb begin
    shaped = invert ? ~pattern : pattern;
    shaped = shaped & width_mask;
    if (!legal)
      shaped = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      legal_q <= 1'b0;
    end else begin
      mask_q  <= shaped;
      legal_q <= legal;
    end
  end

  assert_reject_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !legal_q |-> (mask_q == '0));
endmodule

// File: rtl/bitmask_imm_decoder.sv
module bitmask_imm_decoder
  import bmi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_i,
  input  logic              wide_i,
  input  logic              invert_i,
  output logic [DATA_W-1:0] mask_o,
  output logic              legal_o
);
  bmi_code_t         code;
  logic [LOGW:1]     size_sel;
  logic              legal;
  logic [DATA_W-1:0] pat [LOGW:1];
  logic [DATA_W-1:0] sel_pat;

  assign code = bmi_code_t'(code_i);

  bmi_size_detect #(.LOGW(LOGW)) u_size (
    .clk       (clk),
    .rst       (rst),
    .wide_elem (code.wide_elem),
    .run       (code.run),
    .wide_op   (wide_i),
    .size_sel  (size_sel),
    .legal     (legal)
  );

  // One pattern generator per candidate element size.
  for (genvar g = 1; g <= LOGW; g++) begin : g_elem
    bmi_pattern_gen #(.LOGE(g), .DATA_W(DATA_W)) u_pat (
      .s   (code.run[g-1:0]),
      .r   (code.rot[g-1:0]),
      .rep (pat[g])
    );
  end

  always_comb begin
    sel_pat = '0;
    for (int g = 1; g <= LOGW; g++)
      if (size_sel[g])
        sel_pat = sel_pat | pat[g];
  end

  bmi_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .pattern (sel_pat),
    .legal   (legal),
    .wide_op (wide_i),
    .invert  (invert_i),
    .mask_q  (mask_o),
    .legal_q (legal_o)
  );

  assert_narrow_upper_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(wide_i) |-> (mask_o[DATA_W-1:DATA_W/2] == '0));

  assert_wide_elem_narrow_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(code_i[CODE_W-1]) && !$past(wide_i)) |-> !legal_o);

  assert_full_run_reject_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(code_i[LOGW-1:0]) == '1) |-> !legal_o);

  assert_legal_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
    (legal_o && !$past(invert_i)) |-> (mask_o != '0));
endmodule

// File: tb/bitmask_imm_decoder_test.sv
module bitmask_imm_decoder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] code_i = '0;
  logic        wide_i = 1'b0;
  logic        invert_i = 1'b0;
  logic [63:0] mask_o;
  logic        legal_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bitmask_imm_decoder uut (
    .clk(clk), .rst(rst), .code_i(code_i), .wide_i(wide_i),
    .invert_i(invert_i), .mask_o(mask_o), .legal_o(legal_o)
  );

  // Behavioural model: shifts and doubling on wide integers.
  function automatic void model(input logic [12:0] c, input bit w, input bit inv,
                                output logic [63:0] v, output bit ok);
    int e, s, r, width;
    logic [127:0] el, acc;
    logic [5:0] imms;
    imms = c[5:0];
    v = '0; ok = 0; e = 0;
    if (c[12]) e = 64;
    else
      for (int p = 5; p >= 1; p--)
        if (e == 0 && imms[p] == 1'b0) e = 1 << p;
    if (e == 0) return;
    if (e == 64 && !w) return;
    s = int'(c[5:0]) % e;
    r = int'(c[11:6]) % e;
    if (s == e - 1) return;
    el = (128'h1 << (s + 1)) - 128'h1;
    if (r != 0) el = ((el >> r) | (el << (e - r))) & ((128'h1 << e) - 128'h1);
    acc = el; width = e;
    while (width < 64) begin
      acc = acc | (acc << width);
      width = width * 2;
    end
    v = acc[63:0];
    if (inv) v = ~v;
    if (!w) v = v & 64'h0000_0000_FFFF_FFFF;
    ok = 1;
  endfunction

  task automatic compare(input logic [63:0] ev, input bit el, input string tag);
    checks++;
    if (mask_o !== ev || legal_o !== el) begin
      failures++;
      $display("FAIL %s: mask=%h legal=%b expected mask=%h legal=%b",
               tag, mask_o, legal_o, ev, el);
    end
  endtask

  task automatic apply(input logic [12:0] c, input bit w, input bit inv);
    @(negedge clk);
    code_i = c; wide_i = w; invert_i = inv;
    @(negedge clk);
  endtask

  task automatic directed(input logic [12:0] c, input bit w, input bit inv,
                          input logic [63:0] ev, input bit el, input string tag);
    apply(c, w, inv);
    compare(ev, el, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      failures++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    compare(64'h0, 1'b0, "R11 reset");
    rst = 1'b0;

    directed(13'h1103, 1, 0, 64'hF000_0000_0000_0000, 1, "R1 layout");
    directed(13'h003E, 1, 0, 64'h0, 0, "R2 reserved size");
    directed(13'h1000, 1, 0, 64'h1, 1, "R3 single one");
    directed(13'h1040, 1, 0, 64'h8000_0000_0000_0000, 1, "R3 rotate");
    directed(13'h0840, 1, 0, 64'h8000_0000_8000_0000, 1, "R4 high rot ignored");
    directed(13'h001F, 1, 0, 64'h0, 0, "R5 full run 32");
    directed(13'h103F, 1, 0, 64'h0, 0, "R5 full run 64");
    directed(13'h003C, 1, 0, 64'h5555_5555_5555_5555, 1, "R6 replicate");
    directed(13'h1000, 0, 0, 64'h0, 0, "R7 wide elem narrow op");
    directed(13'h0840, 0, 0, 64'h0000_0000_8000_0000, 1, "R8 narrow trim");
    directed(13'h003C, 0, 0, 64'h0000_0000_5555_5555, 1, "R8 narrow replicate");
    directed(13'h1000, 1, 1, 64'hFFFF_FFFF_FFFF_FFFE, 1, "R9 invert wide");
    directed(13'h0000, 0, 1, 64'h0000_0000_FFFF_FFFE, 1, "R9 invert narrow");
    directed(13'h003E, 1, 1, 64'h0, 0, "R10 invert on reject");

    // Registered latency: output follows one edge after the input changes.
    @(negedge clk);
    code_i = 13'h1040; wide_i = 1; invert_i = 0;
    compare(64'h0, 1'b0, "R11 holds previous");
    @(negedge clk);
    compare(64'h8000_0000_0000_0000, 1'b1, "R11 one edge");

    // Exhaustive sweep against the model.
    for (int w = 0; w < 2; w++)
      for (int inv = 0; inv < 2; inv++)
        for (int c = 0; c < 8192; c++) begin
          logic [63:0] ev;
          bit el;
          model(13'(c), w[0], inv[0], ev, el);
          apply(13'(c), w[0], inv[0]);
          compare(ev, el, el ? "R3 sweep legal" : "R10 sweep reject");
        end

    finish_run();
  end
endmodule